// File: doc/BRIEF.md
# Triggered Time-of-Day Counter

The block keeps a running time-of-day value made of a sub-nanosecond fraction, a nanosecond count and a seconds count, 88 bits in all. On every clock edge it adds a fixed increment set by parameters. The nanosecond field wraps into the seconds field. A one-cycle pulse marks each seconds rollover, and an optional mode keeps only the pulses that land on even seconds.

Software reaches the counter through two command ports. A read command names a trigger. When that trigger fires, the whole time value is copied into a capture register. A write command names a trigger, a write type and a value. When its trigger fires, the value either replaces the time or is added to it or subtracted from it.

Triggers can be immediate, the internal pulse-per-second, or a rising edge on one of the external event lines. Each external line is synchronised before its edge is detected. Each completed read and each applied write advances its own counter, so software can poll for completion.

Top module: `tod_clock`

## Requirements
- R1: When cfg_i bit 0 is 1, time_o advances on every clock by the increment {INC_NS, INC_SUB} (nanoseconds, then 1/256 ns). When cfg_i bit 0 is 0, time_o holds its value.
- R2: time_o is packed as seconds [87:40], nanoseconds [39:8] and sub-ns [7:0]. The sub-ns field carries into nanoseconds at 256. The nanosecond field carries into seconds when it reaches 1,000,000,000.
- R3: Read trigger codes on rd_trig_i are: 0 cancels an armed read with no capture, 1 captures on the edge that accepts the command, 2 uses the internal pulse, 3 uses ref_i[rd_ref_sel_i], 4 uses pwm_pps_i[rd_pwm_sel_i], 6 uses freq_evt_i and 7 uses gpio_trig_i. Code 5 and codes 8 to 15 leave the reader idle and capture nothing.
- R4: Write trigger codes on wr_trig_i are: 0 disables, 1 applies on the edge that accepts the command, 2 uses ref_i[wr_ref_sel_i], 3 uses pwm_pps_i[wr_pwm_sel_i], 4 uses the internal pulse, 5 uses fod_sync_i and 6 uses gpio_trig_i. Codes 7 to 15 leave the writer idle.
- R5: Write type 0 loads wr_time_i as the absolute time. Type 1 adds wr_time_i to the incremented time, and type 2 subtracts it, both with carry or borrow across all three fields. A command with type 3 is rejected and leaves the writer idle.
- R6: pps_o is high for one cycle when counting carries into seconds, aligned with the new seconds value on time_o. When cfg_i bit 2 is 1, only rollovers to an even seconds value produce the pulse. A cycle in which a write is applied produces no pulse. sync_o equals pps_o when cfg_i bit 1 is 1 and is 0 otherwise.
- R7: A capture copies all 88 bits of the time value present at the capturing edge into cap_o, and cap_o holds until the next capture.
- R8: rd_cnt_o increases by exactly one per completed capture, and wr_cnt_o by exactly one per applied write. Both wrap.
- R9: Each external event line passes through two flops before edge detection. A rising edge seen at clock edge k acts at edge k+2. The selectors are used live and pick which of the 16 ref or PWM lines counts.
- R10: An armed command fires at most once and then returns to idle. A new command replaces a pending one, and the old one is never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_i | input | 3 | Bit 0 count enable, bit 1 sync output enable, bit 2 even-second pulse mode |
| wr_cmd_i | input | 1 | Write command strobe |
| wr_trig_i | input | 4 | Write trigger code |
| wr_type_i | input | 2 | Write type: absolute, add, subtract |
| wr_time_i | input | 88 | Write value |
| wr_ref_sel_i | input | 4 | Reference line index for write triggers |
| wr_pwm_sel_i | input | 4 | PWM-decoder line index for write triggers |
| rd_cmd_i | input | 1 | Read command strobe |
| rd_trig_i | input | 4 | Read trigger code |
| rd_ref_sel_i | input | 4 | Reference line index for read triggers |
| rd_pwm_sel_i | input | 4 | PWM-decoder line index for read triggers |
| ref_i | input | 16 | Reference event lines |
| pwm_pps_i | input | 16 | PWM-decoded second pulses |
| gpio_trig_i | input | 1 | General-purpose trigger line |
| fod_sync_i | input | 1 | Output-divider sync pulse |
| freq_evt_i | input | 1 | Frequency-write event |
| time_o | output | 88 | Running time |
| cap_o | output | 88 | Captured time |
| rd_cnt_o | output | 16 | Completed read count |
| wr_cnt_o | output | 16 | Applied write count |
| rd_armed_o | output | 1 | A read is pending |
| wr_armed_o | output | 1 | A write is pending |
| pps_o | output | 1 | Pulse per second |
| sync_o | output | 1 | Output-channel sync pulse |

## Verification
On every cycle, the assertions check four things. The nanosecond field stays below one billion while counting. The pulse lasts one cycle, and in even mode it lands only on even seconds. The counters move by at most one, and cap_o changes only when the read count moves. Each completion also leaves its port idle. Only the bench scenarios can show that each trigger code picks the right source and index with the two-flop delay. They also show that cancel, replacement and reserved codes discard commands, and that random add and subtract writes borrow and carry to exactly the expected time.

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int          SEL_W   = 4,
  parameter int          CNT_W   = 16,
  parameter logic [31:0] INC_NS  = 32'd8,
  parameter logic [7:0]  INC_SUB = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cfg_i,
  input  logic                 wr_cmd_i,
  input  logic [3:0]           wr_trig_i,
  input  logic [1:0]           wr_type_i,
  input  logic [87:0]          wr_time_i,
  input  logic [SEL_W-1:0]     wr_ref_sel_i,
  input  logic [SEL_W-1:0]     wr_pwm_sel_i,
  input  logic                 rd_cmd_i,
  input  logic [3:0]           rd_trig_i,
  input  logic [SEL_W-1:0]     rd_ref_sel_i,
  input  logic [SEL_W-1:0]     rd_pwm_sel_i,
  input  logic [(1<<SEL_W)-1:0] ref_i,
  input  logic [(1<<SEL_W)-1:0] pwm_pps_i,
  input  logic                 gpio_trig_i,
  input  logic                 fod_sync_i,
  input  logic                 freq_evt_i,
  output logic [87:0]          time_o,
  output logic [87:0]          cap_o,
  output logic [CNT_W-1:0]     rd_cnt_o,
  output logic [CNT_W-1:0]     wr_cnt_o,
  output logic                 rd_armed_o,
  output logic                 wr_armed_o,
  output logic                 pps_o,
  output logic                 sync_o
);
  localparam int          NSRC   = 1 << SEL_W;
  localparam int          EW     = 2*NSRC + 3;
  localparam logic [31:0] NS_LIM = 32'd1000000000;
  localparam logic [40:0] FR_LIM = {1'b0, NS_LIM, 8'h00};
  localparam logic [87:0] INC    = {48'd0, INC_NS, INC_SUB};

  function automatic logic [87:0] t_add(input logic [87:0] a, input logic [87:0] d);
    logic [40:0] s;
    logic c;
    s = {1'b0, a[39:0]} + {1'b0, d[39:0]};
    c = (s >= FR_LIM);
    if (c) s = s - FR_LIM;
    return {a[87:40] + d[87:40] + {47'd0, c}, s[39:0]};
  endfunction

  function automatic logic [87:0] t_sub(input logic [87:0] a, input logic [87:0] d);
    logic [40:0] f;
    logic b;
    b = (a[39:0] < d[39:0]);
    f = {1'b0, a[39:0]} - {1'b0, d[39:0]} + (b ? FR_LIM : 41'd0);
    return {a[87:40] - d[87:40] - {47'd0, b}, f[39:0]};
  endfunction

  logic [EW-1:0] s1, s2, s3, rise;
  logic [NSRC-1:0] ref_rise, pwm_rise;
  logic gpio_rise, fod_rise, freq_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {freq_evt_i, fod_sync_i, gpio_trig_i, pwm_pps_i, ref_i};
      s2 <= s1;
      s3 <= s2;
    end

  assign rise      = s2 & ~s3;
  assign ref_rise  = rise[NSRC-1:0];
  assign pwm_rise  = rise[2*NSRC-1:NSRC];
  assign gpio_rise = rise[2*NSRC];
  assign fod_rise  = rise[2*NSRC+1];
  assign freq_rise = rise[2*NSRC+2];

  logic [87:0] time_q, ticked, time_d, wr_val_q, app_val;
  logic [3:0]  rd_mode_q, wr_mode_q;
  logic [1:0]  wr_type_q, app_type;
  logic        rd_armed_q, wr_armed_q, pps_q;
  logic        rd_ev, wr_ev, rd_imm, wr_imm, rd_fire, wr_fire, tick_carry;
  logic        rd_arm_ok, wr_arm_ok;

  always_comb begin
    case (rd_mode_q)
      4'd2:    rd_ev = pps_q;
      4'd3:    rd_ev = ref_rise[rd_ref_sel_i];
      4'd4:    rd_ev = pwm_rise[rd_pwm_sel_i];
      4'd6:    rd_ev = freq_rise;
      4'd7:    rd_ev = gpio_rise;
      default: rd_ev = 1'b0;
    endcase
    case (wr_mode_q)
      4'd2:    wr_ev = ref_rise[wr_ref_sel_i];
      4'd3:    wr_ev = pwm_rise[wr_pwm_sel_i];
      4'd4:    wr_ev = pps_q;
      4'd5:    wr_ev = fod_rise;
      4'd6:    wr_ev = gpio_rise;
      default: wr_ev = 1'b0;
    endcase
  end

  assign rd_imm    = rd_cmd_i && rd_trig_i == 4'd1;
  assign rd_arm_ok = rd_trig_i inside {4'd2, 4'd3, 4'd4, 4'd6, 4'd7};
  assign rd_fire   = rd_imm || (rd_armed_q && !rd_cmd_i && rd_ev);
  assign wr_imm    = wr_cmd_i && wr_trig_i == 4'd1 && wr_type_i != 2'd3;
  assign wr_arm_ok = wr_trig_i inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6} && wr_type_i != 2'd3;
  assign wr_fire   = wr_imm || (wr_armed_q && !wr_cmd_i && wr_ev);
  assign app_type  = wr_imm ? wr_type_i : wr_type_q;
  assign app_val   = wr_imm ? wr_time_i : wr_val_q;

  assign ticked     = cfg_i[0] ? t_add(time_q, INC) : time_q;
  assign tick_carry = ticked[87:40] != time_q[87:40];

  always_comb begin
    if (!wr_fire)              time_d = ticked;
    else if (app_type == 2'd0) time_d = app_val;
    else if (app_type == 2'd1) time_d = t_add(ticked, app_val);
    else                       time_d = t_sub(ticked, app_val);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      time_q     <= '0;
      pps_q      <= 1'b0;
      cap_o      <= '0;
      rd_cnt_o   <= '0;
      wr_cnt_o   <= '0;
      rd_armed_q <= 1'b0;
      rd_mode_q  <= '0;
      wr_armed_q <= 1'b0;
      wr_mode_q  <= '0;
      wr_type_q  <= '0;
      wr_val_q   <= '0;
    end else begin
      time_q <= time_d;
      pps_q  <= tick_carry && !wr_fire && (!cfg_i[2] || !ticked[40]);
      if (rd_fire) begin
        cap_o    <= time_q;
        rd_cnt_o <= rd_cnt_o + 1'b1;
      end
      if (wr_fire) wr_cnt_o <= wr_cnt_o + 1'b1;
      if (rd_cmd_i) begin
        rd_armed_q <= rd_arm_ok;
        rd_mode_q  <= rd_trig_i;
      end else if (rd_fire) rd_armed_q <= 1'b0;
      if (wr_cmd_i) begin
        wr_armed_q <= wr_arm_ok;
        wr_mode_q  <= wr_trig_i;
        wr_type_q  <= wr_type_i;
        wr_val_q   <= wr_time_i;
      end else if (wr_fire) wr_armed_q <= 1'b0;
    end

  assign time_o     = time_q;
  assign pps_o      = pps_q;
  assign sync_o     = pps_q & cfg_i[1];
  assign rd_armed_o = rd_armed_q;
  assign wr_armed_o = wr_armed_q;

  assert_ns_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q[39:8] < NS_LIM && !wr_fire) |=> time_q[39:8] < NS_LIM);
  assert_pps_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pps_q |=> !pps_q);
  assert_even_pps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_q && $past(cfg_i[2])) |-> !time_q[40]);
  assert_rd_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_cnt_o == $past(rd_cnt_o) || rd_cnt_o == $past(rd_cnt_o) + 1'b1));
  assert_wr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_cnt_o == $past(wr_cnt_o) || wr_cnt_o == $past(wr_cnt_o) + 1'b1));
  assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_cnt_o) |-> $stable(cap_o));
  assert_rd_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt_o != $past(rd_cnt_o)) |-> !rd_armed_q);
  assert_wr_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_o != $past(wr_cnt_o)) |-> !wr_armed_q);
endmodule

// File: tb/tod_clock_bench.sv
`timescale 1ns/1ps
module tod_clock_bench;
  localparam logic [31:0] B_NS  = 32'd8;
  localparam logic [7:0]  B_SUB = 8'h40;
  localparam logic [87:0] B_INC = {48'd0, B_NS, B_SUB};
  localparam logic [40:0] B_LIM = 41'd256000000000;

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_i = 3'b001;
  logic wr_cmd_i = 0, rd_cmd_i = 0;
  logic [3:0] wr_trig_i = 0, rd_trig_i = 0;
  logic [1:0] wr_type_i = 0;
  logic [87:0] wr_time_i = 0;
  logic [3:0] wr_ref_sel_i = 0, wr_pwm_sel_i = 0, rd_ref_sel_i = 0, rd_pwm_sel_i = 0;
  logic [15:0] ref_i = 0, pwm_pps_i = 0;
  logic gpio_trig_i = 0, fod_sync_i = 0, freq_evt_i = 0;
  logic [87:0] time_o, cap_o;
  logic [15:0] rd_cnt_o, wr_cnt_o;
  logic rd_armed_o, wr_armed_o, pps_o, sync_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] erc = 0, ewc = 0;

  always #2.5 clk = ~clk;

  tod_clock #(.INC_NS(B_NS), .INC_SUB(B_SUB)) u_tod_clock (.*);

  function automatic logic [87:0] badd(input logic [87:0] a, input logic [87:0] d);
    logic [40:0] s;
    s = {1'b0, a[39:0]} + {1'b0, d[39:0]};
    if (s >= B_LIM) return {a[87:40] + d[87:40] + 48'd1, 40'(s - B_LIM)};
    return {a[87:40] + d[87:40], s[39:0]};
  endfunction

  function automatic logic [87:0] bsub(input logic [87:0] a, input logic [87:0] d);
    if (a[39:0] >= d[39:0]) return {a[87:40] - d[87:40], a[39:0] - d[39:0]};
    return {a[87:40] - d[87:40] - 48'd1, 40'(B_LIM + {1'b0, a[39:0]} - {1'b0, d[39:0]})};
  endfunction

  function automatic logic [87:0] mk(input logic [47:0] s, input logic [31:0] ns, input logic [7:0] sub);
    return {s, ns, sub};
  endfunction

  task automatic chk(input string req, input logic [87:0] act, input logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wcmd(input logic [3:0] trig, input logic [1:0] typ, input logic [87:0] v);
    wr_cmd_i = 1; wr_trig_i = trig; wr_type_i = typ; wr_time_i = v;
    tick();
    wr_cmd_i = 0;
  endtask

  task automatic rcmd(input logic [3:0] trig);
    rd_cmd_i = 1; rd_trig_i = trig;
    tick();
    rd_cmd_i = 0;
  endtask

  task automatic set_src(input int kind, input int idx, input logic v);
    case (kind)
      0: ref_i[idx] = v;
      1: pwm_pps_i[idx] = v;
      2: gpio_trig_i = v;
      3: fod_sync_i = v;
      default: freq_evt_i = v;
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [87:0] t, e, v;
    repeat (3) @(negedge clk);
    chk("R1 reset time", time_o, 0);
    chk("R7 reset capture", cap_o, 0);
    chk("R8 reset counts", {rd_cnt_o, wr_cnt_o}, 0);
    rst_n = 1;
    @(negedge clk);

    t = time_o; tick(3);
    chk("R1 three increments", time_o, badd(badd(badd(t, B_INC), B_INC), B_INC));
    cfg_i = 3'b000; t = time_o; tick(4);
    chk("R1 disabled holds", time_o, t);
    cfg_i = 3'b001;

    v = mk(48'd5, 32'd999999990, 8'h00);
    wcmd(4'd1, 2'd0, v); ewc++;
    chk("R4 immediate absolute load", time_o, v);
    chk("R8 write count", wr_cnt_o, ewc);
    tick();
    chk("R2 sub-ns accumulates", time_o, mk(48'd5, 32'd999999998, 8'h40));
    tick();
    chk("R2 ns wrap into seconds", time_o, mk(48'd6, 32'd6, 8'h80));
    chk("R6 pulse on rollover", pps_o, 1);
    chk("R6 sync off when disabled", sync_o, 0);
    tick();
    chk("R6 single cycle pulse", pps_o, 0);

    cfg_i = 3'b111;
    wcmd(4'd1, 2'd0, mk(48'd8, 32'd999999995, 8'h00)); ewc++;
    tick(2);
    chk("R6 no pulse on odd second in even mode", {pps_o, time_o[87:40]}, {1'b0, 48'd9});
    wcmd(4'd1, 2'd0, mk(48'd9, 32'd999999995, 8'h00)); ewc++;
    tick();
    chk("R6 even second pulse and sync", {pps_o, sync_o, time_o[87:40]}, {2'b11, 48'd10});
    cfg_i = 3'b001;

    wcmd(4'd1, 2'd3, mk(48'd77, 32'd0, 8'h0));
    chk("R5 type 3 rejected", {wr_armed_o, wr_cnt_o, time_o[87:40]}, {1'b0, ewc, 48'd10});

    for (int i = 0; i < 40; i++) begin
      logic [1:0] ty;
      ty = 2'($urandom_range(1, 2));
      if (i == 0) begin ty = 2'd1; v = mk(48'd0, 32'd999999999, 8'hFF); end
      else if (i == 1) begin ty = 2'd2; v = mk(48'd1, 32'd999999999, 8'hFF); end
      else v = mk({16'd0, $urandom}, $urandom % 32'd1000000000, 8'($urandom));
      t = time_o;
      wcmd(4'd1, ty, v); ewc++;
      e = (ty == 2'd1) ? badd(badd(t, B_INC), v) : bsub(badd(t, B_INC), v);
      chk(ty == 2'd1 ? "R5 delta add" : "R5 delta subtract", time_o, e);
    end
    chk("R8 write count after deltas", wr_cnt_o, ewc);

    t = time_o; rcmd(4'd1); erc++;
    chk("R3 immediate capture", cap_o, t);
    chk("R8 read count", rd_cnt_o, erc);
    tick(3);
    chk("R7 capture held", cap_o, t);

    begin
      int kinds[4] = '{0, 1, 4, 2};
      int codes[4] = '{3, 4, 6, 7};
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = $urandom_range(0, 14);
        rd_ref_sel_i = 4'(idx); rd_pwm_sel_i = 4'(idx);
        rcmd(4'(codes[k]));
        if (kinds[k] < 2) begin
          set_src(kinds[k], idx + 1, 1); tick(4); set_src(kinds[k], idx + 1, 0); tick(3);
          chk("R9 unselected line ignored", {rd_armed_o, rd_cnt_o}, {1'b1, erc});
        end
        set_src(kinds[k], idx, 1); tick(2);
        t = time_o;
        chk("R9 no capture before third edge", rd_cnt_o, erc);
        tick(); erc++;
        chk("R3 event capture", cap_o, t);
        chk("R10 read idle after fire", {rd_armed_o, rd_cnt_o}, {1'b0, erc});
        set_src(kinds[k], idx, 0); tick(3); set_src(kinds[k], idx, 1); tick(4);
        chk("R10 second edge ignored", rd_cnt_o, erc);
        set_src(kinds[k], idx, 0); tick(3);
      end
    end

    rd_ref_sel_i = 4'd2; rcmd(4'd3); rcmd(4'd0);
    ref_i[2] = 1; tick(5); ref_i[2] = 0; tick(3);
    chk("R3 cancel drops armed read", {rd_armed_o, rd_cnt_o}, {1'b0, erc});
    rcmd(4'd5);
    freq_evt_i = 1; tick(5); freq_evt_i = 0; tick(3);
    chk("R3 reserved code idle", {rd_armed_o, rd_cnt_o}, {1'b0, erc});

    begin
      int kinds[4] = '{0, 1, 3, 2};
      int codes[4] = '{2, 3, 5, 6};
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = $urandom_range(0, 15);
        wr_ref_sel_i = 4'(idx); wr_pwm_sel_i = 4'(idx);
        v = mk(48'(1000 + k), 32'(k * 1000), 8'h10);
        wcmd(4'(codes[k]), 2'd0, v);
        set_src(kinds[k], idx, 1); tick(3); ewc++;
        chk("R4 event write applied", time_o, v);
        chk("R10 write idle after fire", {wr_armed_o, wr_cnt_o}, {1'b0, ewc});
        set_src(kinds[k], idx, 0); tick(3);
      end
    end

    wr_ref_sel_i = 4'd3;
    wcmd(4'd2, 2'd0, mk(48'd111, 32'd0, 8'h0));
    wcmd(4'd6, 2'd0, mk(48'd222, 32'd0, 8'h0));
    ref_i[3] = 1; tick(5); ref_i[3] = 0; tick(2);
    chk("R10 replaced write not applied", {wr_armed_o, wr_cnt_o}, {1'b1, ewc});
    gpio_trig_i = 1; tick(3); gpio_trig_i = 0; ewc++;
    chk("R10 replacing write applied", time_o, mk(48'd222, 32'd0, 8'h0));
    wcmd(4'd0, 2'd0, 88'd0);
    fod_sync_i = 1; tick(5); fod_sync_i = 0; tick(2);
    chk("R4 disabled write idle", {wr_armed_o, wr_cnt_o}, {1'b0, ewc});

    wcmd(4'd1, 2'd0, mk(48'd20, 32'd999999990, 8'h00)); ewc++;
    v = mk(48'd500, 32'd12345, 8'h01);
    wcmd(4'd4, 2'd0, v);
    rcmd(4'd2);
    chk("R6 pulse seen for pulse triggers", pps_o, 1);
    t = time_o;
    tick(); ewc++; erc++;
    chk("R4 write on internal pulse", time_o, v);
    chk("R3 capture on internal pulse", cap_o, t);
    chk("R8 final counts", {rd_cnt_o, wr_cnt_o}, {erc, ewc});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule